// File: doc/BRIEF.md
# Byte-Lane Dual-Port Synchronous RAM

This block is a true dual-port static RAM built from 18-bit words. Each word is split into two 9-bit byte lanes. The address width is a parameter: `ADDR_W = 14` gives the full 16K-word array, and the default of 10 keeps elaboration small. Ports A and B are fully independent. Each has its own clock, its own synchronous active-high reset, its own address, write data and controls. Both ports can reach any word at the same moment.

A port is active only when its active-low enable is low and its active-high enable is high. The write-not-read select picks between writing and reading. In a write, only the lanes whose active-low lane select is low are stored. In a read, the port drives only the selected lanes, and only while its asynchronous active-low output enable is low.

The drive vector marks which lanes of the read bus are actively driven. It stands in for a tri-state bus. A static mode pin on each port chooses between two read latencies:
- Flow-through: read data and drive appear after the same edge that registers the address.
- Pipelined: read data and drive appear one edge later.

In pipelined mode the chip enables and the write-not-read select travel with the address through both stages. The lane selects always take effect at the next edge, whatever the mode.

Top module: `dpram_top`

## Requirements
- R1: A port is selected only when its `ce_n` is 0 and its `ce` is 1 at a clock edge. Any other pair blocks writes at that edge. In flow-through mode it also forces the port's drive to 0 after that edge.
- R2: A selected write (`wr_n` = 0) stores only the lanes whose `lane_n` bit is 0. Lane 0 is bits 8:0 and lane 1 is bits 17:9. The other lanes of the word keep their previous contents.
- R3: A selected read (`wr_n` = 1) drives lane l only when `lane_n[l]` was 0 and `oe_n` is currently 0. `oe_n` acts at once, without waiting for a clock edge.
- R4: With `pipe` = 0, the word at the address registered at edge k is on `rdata` after edge k. The matching drive bits are also set after edge k.
- R5: With `pipe` = 1, the word at the address registered at edge k appears on `rdata` after edge k+1, together with its drive.
- R6: With `pipe` = 1, the enable pair and `wr_n` act two edges after they are sampled, so deselecting a port keeps it driving for one more cycle. Lane selects act one edge after sampling in both modes.
- R7: When one port reads a word at the same edge that the other port writes it, the read returns the newly written lanes. This holds in both modes.
- R8: A reading port whose address and controls stay unchanged, with no intervening writes, keeps presenting the same data and drive on later cycles.
- R9: While `rst` is 1 at an edge, the port's drive is cleared after that edge, whatever its other inputs are. The stored words are not altered by the reset.
- R10: A word written through either port is readable through the other port. When the two ports have written different lanes of one word, each lane returns the port's value that was written last to that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst | input | 1 | Port A synchronous reset, active high |
| a_ce_n | input | 1 | Port A enable, active low |
| a_ce | input | 1 | Port A enable, active high |
| a_wr_n | input | 1 | Port A: 0 writes, 1 reads |
| a_lane_n | input | LANES | Port A lane selects, active low |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe | input | 1 | Port A read mode: 0 flow-through, 1 pipelined |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | LANE_W*LANES | Port A write data |
| a_rdata | output | LANE_W*LANES | Port A read data |
| a_drive | output | LANES | Port A per-lane drive (1 = lane driven) |
| b_clk | input | 1 | Port B clock |
| b_rst | input | 1 | Port B synchronous reset, active high |
| b_ce_n | input | 1 | Port B enable, active low |
| b_ce | input | 1 | Port B enable, active high |
| b_wr_n | input | 1 | Port B: 0 writes, 1 reads |
| b_lane_n | input | LANES | Port B lane selects, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe | input | 1 | Port B read mode: 0 flow-through, 1 pipelined |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | LANE_W*LANES | Port B write data |
| b_rdata | output | LANE_W*LANES | Port B read data |
| b_drive | output | LANES | Port B per-lane drive (1 = lane driven) |

## Verification
The hardest situation to reach is a word whose two lanes were last written by different ports. The hardest timing is a read that lands on the very edge where the other port writes the same word. To reach both, the bench runs both ports from one clock and stacks a write on one port and a read on the other into the same cycle, in each direction and in both latency modes. It then overwrites a single lane from the opposite port and reads the word back. Around this, the bench sweeps every enable and lane-select combination against the output enable and checks the two-stage enable against the one-stage lane selects.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  typedef enum logic {
    OUT_FLOW = 1'b0,
    OUT_PIPE = 1'b1
  } out_mode_e;

  // A port is active only for the low/high enable pair.
  function automatic logic port_sel(input logic ce_n, input logic ce);
    return !ce_n && ce;
  endfunction

endpackage

// File: rtl/dpram_bank.sv
module dpram_bank #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  parameter bit INVERT = 1'b0,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic                   clk,
  input  logic [LANES-1:0]       wr_lane,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic [LANES-1:0]       peer_lvt,
  input  logic [ADDR_W-1:0]      peek_addr,
  output logic [LANES-1:0]       peek_lvt,
  input  logic [1:0][ADDR_W-1:0] rd_addr,
  output logic [1:0][WORD_W-1:0] rd_data,
  output logic [1:0][LANES-1:0]  rd_lvt
);

  localparam int DEPTH = 1 << ADDR_W;

  // One writer per bank; the lane tags record which bank is newest per lane.
  logic [WORD_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  lvt [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = '0;
      lvt[i] = '0;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (wr_lane[l]) begin
        mem[wr_addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
        lvt[wr_addr][l]                  <= peer_lvt[l] ^ INVERT;
      end
    end
  end

  assign peek_lvt = lvt[peek_addr];

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd_data[p] = mem[rd_addr[p]];
    assign rd_lvt[p]  = lvt[rd_addr[p]];
  end

endmodule

// File: rtl/dpram_port.sv
module dpram_port
  import dpram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              wr_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              oe_n,
  input  logic              pipe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [WORD_W-1:0] live_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LANES-1:0]  wr_lane,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rdata,
  output logic [LANES-1:0]  drive
);

  logic              sel_now;
  logic [ADDR_W-1:0] addr_q;
  logic              sel_q, rd_q, sel_q2, rd_q2;
  logic [LANES-1:0]  lane_q;
  logic [WORD_W-1:0] data_q2;
  logic              read_en;
  out_mode_e         mode;

  assign sel_now = port_sel(ce_n, ce);
  assign wr_lane = (sel_now && !wr_n && !rst) ? ~lane_n : '0;
  assign wr_addr = addr;
  assign wr_data = wdata;
  assign rd_addr = addr_q;
  assign mode    = out_mode_e'(pipe);

  // Stage 1: address, enables and lanes; stage 2: enables and data only.
  always_ff @(posedge clk) begin
    addr_q  <= addr;
    data_q2 <= live_data;
    if (rst) begin
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      lane_q <= '1;
      sel_q2 <= 1'b0;
      rd_q2  <= 1'b0;
    end else begin
      sel_q  <= sel_now;
      rd_q   <= wr_n;
      lane_q <= lane_n;
      sel_q2 <= sel_q;
      rd_q2  <= rd_q;
    end
  end

  always_comb begin
    if (mode == OUT_PIPE) begin
      read_en = sel_q2 && rd_q2;
      rdata   = data_q2;
    end else begin
      read_en = sel_q && rd_q;
      rdata   = live_data;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_drv
    assign drive[l] = read_en && !oe_n && !lane_q[l];
  end

endmodule

// File: rtl/dpram_top.sv
module dpram_top #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 9,
  parameter int LANES  = 2,
  localparam int WORD_W = LANE_W * LANES
) (
  input  logic              a_clk,
  input  logic              a_rst,
  input  logic              a_ce_n,
  input  logic              a_ce,
  input  logic              a_wr_n,
  input  logic [LANES-1:0]  a_lane_n,
  input  logic              a_oe_n,
  input  logic              a_pipe,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  output logic [LANES-1:0]  a_drive,
  input  logic              b_clk,
  input  logic              b_rst,
  input  logic              b_ce_n,
  input  logic              b_ce,
  input  logic              b_wr_n,
  input  logic [LANES-1:0]  b_lane_n,
  input  logic              b_oe_n,
  input  logic              b_pipe,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata,
  output logic [LANES-1:0]  b_drive
);

  logic [1:0]                        clk_v;
  logic [1:0][ADDR_W-1:0]            rd_addr, wr_addr;
  logic [1:0][LANES-1:0]             wr_lane, peek_lvt;
  logic [1:0][WORD_W-1:0]            wr_data, live;
  logic [1:0][1:0][WORD_W-1:0]       bdat;
  logic [1:0][1:0][LANES-1:0]        blvt;

  assign clk_v = {b_clk, a_clk};

  dpram_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_port_a (
    .clk(a_clk), .rst(a_rst), .ce_n(a_ce_n), .ce(a_ce), .wr_n(a_wr_n),
    .lane_n(a_lane_n), .oe_n(a_oe_n), .pipe(a_pipe), .addr(a_addr),
    .wdata(a_wdata), .live_data(live[0]), .rd_addr(rd_addr[0]),
    .wr_lane(wr_lane[0]), .wr_addr(wr_addr[0]), .wr_data(wr_data[0]),
    .rdata(a_rdata), .drive(a_drive)
  );

  dpram_port #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_port_b (
    .clk(b_clk), .rst(b_rst), .ce_n(b_ce_n), .ce(b_ce), .wr_n(b_wr_n),
    .lane_n(b_lane_n), .oe_n(b_oe_n), .pipe(b_pipe), .addr(b_addr),
    .wdata(b_wdata), .live_data(live[1]), .rd_addr(rd_addr[1]),
    .wr_lane(wr_lane[1]), .wr_addr(wr_addr[1]), .wr_data(wr_data[1]),
    .rdata(b_rdata), .drive(b_drive)
  );

  // Bank i is written only by port i; its tag copies (A) or inverts (B) the peer tag.
  for (genvar i = 0; i < 2; i++) begin : g_bank
    dpram_bank #(
      .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES), .INVERT(i == 1)
    ) u_bank (
      .clk      (clk_v[i]),
      .wr_lane  (wr_lane[i]),
      .wr_addr  (wr_addr[i]),
      .wr_data  (wr_data[i]),
      .peer_lvt (peek_lvt[1-i]),
      .peek_addr(wr_addr[1-i]),
      .peek_lvt (peek_lvt[i]),
      .rd_addr  (rd_addr),
      .rd_data  (bdat[i]),
      .rd_lvt   (blvt[i])
    );
  end

  // Equal tags: port A wrote the lane last; different tags: port B did.
  always_comb begin
    for (int p = 0; p < 2; p++) begin
      for (int l = 0; l < LANES; l++) begin
        live[p][l*LANE_W +: LANE_W] = (blvt[0][p][l] == blvt[1][p][l])
                                      ? bdat[0][p][l*LANE_W +: LANE_W]
                                      : bdat[1][p][l*LANE_W +: LANE_W];
      end
    end
  end

endmodule

// File: rtl/dpram_chk.sv
module dpram_chk #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             ce_n,
  input logic             ce,
  input logic             wr_n,
  input logic [LANES-1:0] lane_n,
  input logic             oe_n,
  input logic             pipe,
  input logic [LANES-1:0] drive
);

  p_desel_flow_r1: assert property (@(posedge clk) disable iff (rst)
    (!pipe && !($past(!ce_n) && $past(ce))) |-> (drive == '0));

  p_write_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (!pipe && !$past(wr_n)) |-> (drive == '0));

  p_oe_off_r3: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (drive == '0));

  p_desel_pipe_r6: assert property (@(posedge clk) disable iff (rst)
    (pipe && !($past(!ce_n, 2) && $past(ce, 2))) |-> (drive == '0));

  p_write_quiet_pipe_r5: assert property (@(posedge clk) disable iff (rst)
    (pipe && !$past(wr_n, 2)) |-> (drive == '0));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    p_lane_next_r6: assert property (@(posedge clk) disable iff (rst)
      drive[l] |-> !$past(lane_n[l]));
  end

endmodule

bind dpram_top dpram_chk #(.LANES(LANES)) u_chk_a (
  .clk(a_clk), .rst(a_rst), .ce_n(a_ce_n), .ce(a_ce), .wr_n(a_wr_n),
  .lane_n(a_lane_n), .oe_n(a_oe_n), .pipe(a_pipe), .drive(a_drive)
);

bind dpram_top dpram_chk #(.LANES(LANES)) u_chk_b (
  .clk(b_clk), .rst(b_rst), .ce_n(b_ce_n), .ce(b_ce), .wr_n(b_wr_n),
  .lane_n(b_lane_n), .oe_n(b_oe_n), .pipe(b_pipe), .drive(b_drive)
);

// File: tb/tb_dpram_top.sv
module tb_dpram_top;

  localparam int AW = 10;
  localparam int LW = 9;
  localparam int NL = 2;
  localparam int WW = LW * NL;

  logic clk = 1'b0;
  logic rst;
  logic a_ce_n, a_ce, a_wr_n, a_oe_n, a_pipe;
  logic b_ce_n, b_ce, b_wr_n, b_oe_n, b_pipe;
  logic [NL-1:0] a_lane_n, b_lane_n;
  logic [AW-1:0] a_addr, b_addr;
  logic [WW-1:0] a_wdata, b_wdata;
  logic [WW-1:0] a_rdata, b_rdata;
  logic [NL-1:0] a_drive, b_drive;

  logic [WW-1:0] ref_mem [1 << AW];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpram_top #(.ADDR_W(AW), .LANE_W(LW), .LANES(NL)) dut (
    .a_clk(clk), .a_rst(rst), .a_ce_n(a_ce_n), .a_ce(a_ce), .a_wr_n(a_wr_n),
    .a_lane_n(a_lane_n), .a_oe_n(a_oe_n), .a_pipe(a_pipe), .a_addr(a_addr),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drive(a_drive),
    .b_clk(clk), .b_rst(rst), .b_ce_n(b_ce_n), .b_ce(b_ce), .b_wr_n(b_wr_n),
    .b_lane_n(b_lane_n), .b_oe_n(b_oe_n), .b_pipe(b_pipe), .b_addr(b_addr),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drive(b_drive)
  );

  function automatic logic [WW-1:0] pat(input int a);
    return WW'((a * 1237 + 91) & ((1 << WW) - 1));
  endfunction

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old_w,
                                          input logic [WW-1:0] new_w,
                                          input logic [NL-1:0] lane_n);
    logic [WW-1:0] r = old_w;
    for (int l = 0; l < NL; l++)
      if (!lane_n[l]) r[l*LW +: LW] = new_w[l*LW +: LW];
    return r;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_a(input logic ce_n, input logic ce, input logic wr_n,
                       input logic [NL-1:0] lane_n, input int addr,
                       input logic [WW-1:0] d);
    a_ce_n = ce_n; a_ce = ce; a_wr_n = wr_n; a_lane_n = lane_n;
    a_addr = AW'(addr); a_wdata = d;
  endtask

  task automatic set_b(input logic ce_n, input logic ce, input logic wr_n,
                       input logic [NL-1:0] lane_n, input int addr,
                       input logic [WW-1:0] d);
    b_ce_n = ce_n; b_ce = ce; b_wr_n = wr_n; b_lane_n = lane_n;
    b_addr = AW'(addr); b_wdata = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=completed");
    finish_run();
  end

  initial begin
    logic [WW-1:0] held;
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    a_oe_n = 1'b0; b_oe_n = 1'b0; a_pipe = 1'b0; b_pipe = 1'b0;
    set_a(1, 0, 1, 2'b11, 0, 0);
    set_b(0, 1, 1, 2'b00, 0, 0);   // selected read held off by reset
    rst = 1'b1;
    tick(); tick(); tick();
    chk("R9", "drive B under reset", 32'(b_drive), 32'h0);
    chk("R9", "drive A under reset", 32'(a_drive), 32'h0);
    set_b(1, 0, 1, 2'b11, 0, 0);
    rst = 1'b0;
    tick();
    chk("R9", "drive A after reset", 32'(a_drive), 32'h0);
    chk("R9", "drive B after reset", 32'(b_drive), 32'h0);

    // R10: fill through A, read back through B (flow-through, R4)
    for (int i = 0; i < 64; i++) begin
      set_a(0, 1, 0, 2'b00, i, pat(i));
      ref_mem[i] = pat(i);
      tick();
    end
    set_a(1, 0, 1, 2'b11, 0, 0);
    for (int i = 0; i < 64; i++) begin
      set_b(0, 1, 1, 2'b00, i, 0);
      tick();
      chk("R4", "flow data B", 32'(b_rdata), 32'(ref_mem[i]));
      chk("R10", "drive B", 32'(b_drive), 32'h3);
    end

    // R2: lane-masked writes
    for (int m = 0; m < 4; m++) begin
      set_a(0, 1, 0, 2'(m), 200 + m, ~pat(200 + m));
      ref_mem[200 + m] = merge(ref_mem[200 + m], ~pat(200 + m), 2'(m));
      tick();
    end
    // R1: writes attempted while deselected
    for (int c = 0; c < 3; c++) begin
      set_a(c == 2 ? 1'b1 : 1'(c), c == 2 ? 1'b1 : 1'b0, 0, 2'b00, 300 + c, 18'h3FFFF);
      tick();
    end
    set_a(1, 0, 1, 2'b11, 0, 0);
    for (int m = 0; m < 4; m++) begin
      set_b(0, 1, 1, 2'b00, 200 + m, 0);
      tick();
      chk("R2", "lane write", 32'(b_rdata), 32'(ref_mem[200 + m]));
    end
    for (int c = 0; c < 3; c++) begin
      set_b(0, 1, 1, 2'b00, 300 + c, 0);
      tick();
      chk("R1", "deselected write ignored", 32'(b_rdata), 32'h0);
    end

    // R1/R3: enable, lane and output-enable sweep (flow-through)
    for (int c = 0; c < 16; c++) begin
      for (int o = 0; o < 2; o++) begin
        logic [NL-1:0] exp_d;
        set_b(c[0], c[1], 1, c[3:2], 5, 0);
        b_oe_n = o[0];
        exp_d = (!c[0] && c[1] && !o[0]) ? ~c[3:2] : 2'b00;
        tick();
        chk("R1", "sweep drive", 32'(b_drive), 32'(exp_d));
        if (exp_d != 0) chk("R3", "sweep data", 32'(b_rdata), 32'(ref_mem[5]));
      end
    end
    b_oe_n = 1'b0;

    // R3: output enable acts without a clock edge
    set_b(0, 1, 1, 2'b00, 7, 0);
    tick();
    b_oe_n = 1'b1; #1;
    chk("R3", "async oe off", 32'(b_drive), 32'h0);
    b_oe_n = 1'b0; #1;
    chk("R3", "async oe on", 32'(b_drive), 32'h3);
    set_b(1, 0, 1, 2'b11, 0, 0);
    tick();

    // R5: pipelined stream on B
    b_pipe = 1'b1;
    tick();
    for (int i = 0; i < 16; i++) begin
      set_b(0, 1, 1, 2'b00, 10 + i, 0);
      tick();
      if (i == 0) chk("R5", "pipe first edge drive", 32'(b_drive), 32'h0);
      else begin
        chk("R5", "pipe data", 32'(b_rdata), 32'(ref_mem[10 + i - 1]));
        chk("R5", "pipe drive", 32'(b_drive), 32'h3);
      end
    end
    // R6: chip enable takes two edges in pipelined mode
    set_b(1, 0, 1, 2'b00, 25, 0);
    tick();
    chk("R6", "pipe deselect still driving", 32'(b_drive), 32'h3);
    chk("R6", "pipe last data", 32'(b_rdata), 32'(ref_mem[25]));
    tick();
    chk("R6", "pipe deselect second edge", 32'(b_drive), 32'h0);
    // R6: lane select takes one edge
    set_b(0, 1, 1, 2'b00, 30, 0);
    tick(); tick();
    chk("R6", "pipe both lanes", 32'(b_drive), 32'h3);
    set_b(0, 1, 1, 2'b10, 30, 0);
    tick();
    chk("R6", "pipe lane one edge", 32'(b_drive), 32'h1);
    set_b(0, 1, 1, 2'b00, 30, 0);
    tick();
    chk("R6", "pipe lane back", 32'(b_drive), 32'h3);
    // R8: pipelined hold
    held = b_rdata;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8", "pipe hold", 32'(b_rdata), 32'(held));
    end
    chk("R8", "pipe hold value", 32'(held), 32'(ref_mem[30]));

    // R7: same-edge write on A, pipelined read on B
    set_a(0, 1, 0, 2'b00, 41, 18'h2C3A7);
    set_b(0, 1, 1, 2'b00, 41, 0);
    ref_mem[41] = 18'h2C3A7;
    tick();
    set_a(1, 0, 1, 2'b11, 0, 0);
    tick();
    chk("R7", "pipe same-edge read", 32'(b_rdata), 32'(ref_mem[41]));
    set_b(1, 0, 1, 2'b11, 0, 0);
    tick(); tick();
    b_pipe = 1'b0;
    tick();

    // R7: same-edge write on A, flow read on B
    set_a(0, 1, 0, 2'b00, 40, 18'h15A5A);
    set_b(0, 1, 1, 2'b00, 40, 0);
    ref_mem[40] = 18'h15A5A;
    tick();
    chk("R7", "flow same-edge read B", 32'(b_rdata), 32'(ref_mem[40]));
    // R7: reverse direction, B writes while A reads
    set_a(0, 1, 1, 2'b00, 42, 0);
    set_b(0, 1, 0, 2'b00, 42, 18'h0F0F1);
    ref_mem[42] = 18'h0F0F1;
    tick();
    chk("R7", "flow same-edge read A", 32'(a_rdata), 32'(ref_mem[42]));
    // R10: A overwrites only lane 0 of a word last written by B
    set_b(1, 0, 1, 2'b11, 0, 0);
    set_a(0, 1, 0, 2'b10, 42, 18'h3FE00 | 18'h00123);
    ref_mem[42] = merge(ref_mem[42], 18'h3FF23, 2'b10);
    tick();
    set_a(1, 0, 1, 2'b11, 0, 0);
    set_b(0, 1, 1, 2'b00, 42, 0);
    tick();
    chk("R10", "mixed-lane word via B", 32'(b_rdata), 32'(ref_mem[42]));
    set_b(1, 0, 1, 2'b11, 0, 0);
    set_a(0, 1, 1, 2'b00, 42, 0);
    tick();
    chk("R10", "mixed-lane word via A", 32'(a_rdata), 32'(ref_mem[42]));

    // R8: flow hold
    set_a(1, 0, 1, 2'b11, 0, 0);
    set_b(0, 1, 1, 2'b00, 50, 0);
    tick();
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8", "flow hold data", 32'(b_rdata), 32'(ref_mem[50]));
      chk("R8", "flow hold drive", 32'(b_drive), 32'h3);
    end

    finish_run();
  end

endmodule